// File: doc/BRIEF.md
# Keyboard Matrix Scanner

This block scans an 8 by 8 key matrix in hardware. It pulls one row line low at a time and moves that low level to the next row on each scan tick. On every tick it samples eight active-low column lines. If any column reads low while a row is driven, the scanner stops rotating and starts a confirmation count on that row. When the same column pattern has been seen on enough consecutive ticks, the scanner emits a one-cycle valid strobe together with a 6-bit key code. The column part of the code is the lowest-numbered low column. The row part is the driven row.

After a report the scanner stays on the same row and waits. It resumes rotating only when a tick finds every column high, so a key held down is reported once.

The control is a four-state machine:
- `ST_SCAN`: rotating.
- `ST_CONFIRM`: counting identical samples.
- `ST_REPORT`: a single cycle that carries the strobe.
- `ST_HOLD`: waiting for release.

The transitions are:
- scan-to-confirm: a tick sees a low column.
- scan-advance: a tick sees all columns high.
- confirm-restart: a tick sees a different non-idle pattern.
- confirm-abandon: a tick sees all columns high, so the machine returns to scan and advances.
- confirm-to-report: the final matching tick.
- report-to-hold: unconditional.
- hold-release: a tick sees all columns high, so the machine returns to scan and advances.

Top module: `keymatrix_scanner`

## Requirements
- R1: While reset is asserted and just after it, row_n is 8'hFE (row 0 driven), key_valid is 0 and key_code is 0.
- R2: Exactly one bit of row_n is low in every cycle.
- R3: In the scanning state, a scan tick that finds col_n equal to 8'hFF moves the low bit to the next row, modulo 8 (row 7 wraps to row 0). row_n never changes on a cycle without a tick.
- R4: A tick that finds any col_n bit low never advances the row.
- R5: A report is made only after the same col_n pattern has been sampled on 4 consecutive ticks of one row. A different non-idle pattern restarts the count at one. An all-high sample abandons the count and advances the row.
- R6: The column index is the position of the lowest-numbered low bit of col_n.
- R7: key_code is {column index, row index}: bits 5..3 hold the column index and bits 2..0 hold the row index, giving values 0 to 63.
- R8: key_valid is high for exactly one cycle, the cycle after the edge that sampled the fourth matching tick.
- R9: After a report, row_n holds and no further report occurs until a tick samples col_n equal to 8'hFF. That tick also advances the row.
- R10: key_code keeps its value between reports and changes only in a cycle where key_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-cycle enable that paces rotation and sampling |
| col_n | input | 8 | Column sense lines, low means a key is closed on the driven row |
| row_n | output | 8 | Row drive lines, exactly one low |
| key_code | output | 6 | Column index in bits 5..3, row index in bits 2..0 |
| key_valid | output | 1 | One-cycle strobe marking a new key_code |

## Verification
The bench targets four corner cases, each with the failure it would expose:
- Keys at code 0 and code 63. A swapped or mis-sized code field would report the wrong values there.
- Two keys closed on one row. An encoder that picks the highest low bit would report column 6 instead of column 2.
- A press released after two ticks. A filter that reports early would emit a spurious strobe.
- A pattern that changes in the middle of confirmation. A filter that kept its count would report too soon or report the stale column.

A long hold is also checked for a repeat strobe, which a scanner that resumed rotating too early would produce.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
    typedef enum logic [1:0] {
        ST_SCAN,
        ST_CONFIRM,
        ST_REPORT,
        ST_HOLD
    } scan_state_e;
endpackage

// File: rtl/kbd_row_driver.sv
module kbd_row_driver #(
    parameter int ROWS  = 8,
    parameter int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] row_idx,
    output logic [ROWS-1:0]  row_n
);
    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx <= '0;
        end else if (advance) begin
            row_idx <= (row_idx == LAST_ROW) ? '0 : row_idx + 1'b1;
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign row_n[g] = (row_idx != IDX_W'(g));
    end
endmodule

// File: rtl/kbd_col_encoder.sv
module kbd_col_encoder #(
    parameter int COLS  = 8,
    parameter int IDX_W = $clog2(COLS)
) (
    input  logic [COLS-1:0]  col_n,
    output logic             any_low,
    output logic [IDX_W-1:0] low_idx
);
    always_comb begin
        low_idx = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (!col_n[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    assign any_low = ~&col_n;
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce #(
    parameter int COLS         = 8,
    parameter int STABLE_TICKS = 4,
    parameter int CNT_W        = $clog2(STABLE_TICKS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [COLS-1:0] col_n,
    output logic            match,
    output logic            last_hit
);
    localparam logic [CNT_W-1:0] FINAL_CNT = CNT_W'(STABLE_TICKS - 1);

    logic [COLS-1:0]  pattern_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern_q <= '1;
            count_q   <= '0;
        end else if (load) begin
            pattern_q <= col_n;
            count_q   <= CNT_W'(1);
        end else if (step) begin
            count_q   <= count_q + 1'b1;
        end
    end

    assign match    = (col_n == pattern_q);
    assign last_hit = (count_q == FINAL_CNT);
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner #(
    parameter int ROWS         = 8,
    parameter int COLS         = 8,
    parameter int STABLE_TICKS = 4,
    parameter int ROW_W        = $clog2(ROWS),
    parameter int COL_W        = $clog2(COLS),
    parameter int CODE_W       = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_tick,
    input  logic [COLS-1:0]   col_n,
    output logic [ROWS-1:0]   row_n,
    output logic [CODE_W-1:0] key_code,
    output logic              key_valid
);
    import kbd_scan_pkg::*;

    localparam bit SINGLE_SAMPLE = (STABLE_TICKS <= 1);

    scan_state_e      state_q, state_d;
    logic             advance, load, step;
    logic             any_low, match, last_hit;
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] low_idx;

    kbd_row_driver #(.ROWS(ROWS), .IDX_W(ROW_W)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .row_idx (row_idx),
        .row_n   (row_n)
    );

    kbd_col_encoder #(.COLS(COLS), .IDX_W(COL_W)) u_cols (
        .col_n   (col_n),
        .any_low (any_low),
        .low_idx (low_idx)
    );

    kbd_debounce #(.COLS(COLS), .STABLE_TICKS(STABLE_TICKS)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .col_n    (col_n),
        .match    (match),
        .last_hit (last_hit)
    );

    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_SCAN: begin
                if (scan_tick) begin
                    if (any_low) begin
                        load    = 1'b1;
                        state_d = SINGLE_SAMPLE ? ST_REPORT : ST_CONFIRM;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (scan_tick) begin
                    if (match) begin
                        if (last_hit) begin
                            state_d = ST_REPORT;
                        end else begin
                            step = 1'b1;
                        end
                    end else if (any_low) begin
                        load = 1'b1;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_SCAN;
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (scan_tick && !any_low) begin
                    advance = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_code  <= '0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= (state_d == ST_REPORT);
            if (state_d == ST_REPORT) begin
                key_code <= {low_idx, row_idx};
            end
        end
    end
endmodule

// File: rtl/kbd_scan_checker.sv
module kbd_scan_checker #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int ROW_W  = 3,
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_tick,
    input logic [COLS-1:0]   col_n,
    input logic [ROWS-1:0]   row_n,
    input logic [CODE_W-1:0] key_code,
    input logic              key_valid
);
    function automatic logic [ROW_W-1:0] driven_row(input logic [ROWS-1:0] r);
        logic [ROW_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (!r[i]) idx = ROW_W'(i);
        end
        return idx;
    endfunction

    assert_one_row_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n) == 1);

    assert_row_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(row_n));

    assert_no_advance_on_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !(&col_n)) |=> $stable(row_n));

    assert_code_row_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_code[ROW_W-1:0] == driven_row(row_n)));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    assert_hold_after_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> $stable(row_n));

    assert_code_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code) |-> key_valid);
endmodule

bind keymatrix_scanner kbd_scan_checker #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .ROW_W  (ROW_W),
    .CODE_W (CODE_W)
) u_scan_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .col_n     (col_n),
    .row_n     (row_n),
    .key_code  (key_code),
    .key_valid (key_valid)
);

// File: tb/keymatrix_scanner_bench.sv
module keymatrix_scanner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_tick = 1'b0;
    logic [7:0] col_n;
    logic [7:0] row_n;
    logic [5:0] key_code;
    logic       key_valid;
    logic [63:0] pressed = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit compare_on = 0;

    int m_state = 0;
    int m_row = 0;
    int m_cnt = 0;
    int m_code = 0;
    bit m_valid = 0;
    logic [7:0] m_pat = 8'hFF;
    int reports[$];

    always #4 clk = ~clk;

    keymatrix_scanner u_keymatrix_scanner (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .col_n     (col_n),
        .row_n     (row_n),
        .key_code  (key_code),
        .key_valid (key_valid)
    );

    always_comb begin
        col_n = 8'hFF;
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                if (!row_n[r] && pressed[r*8+c]) col_n[c] = 1'b0;
            end
        end
    end

    function automatic int lowest_zero(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (!v[i]) return i;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // behavioural reference: 0 scan, 1 confirm, 2 report, 3 hold
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_row = 0; m_cnt = 0; m_code = 0; m_valid = 0; m_pat = 8'hFF;
        end else begin
            m_valid = 0;
            case (m_state)
                0: if (scan_tick) begin
                    if (col_n != 8'hFF) begin m_pat = col_n; m_cnt = 1; m_state = 1; end
                    else m_row = (m_row + 1) % 8;
                end
                1: if (scan_tick) begin
                    if (col_n == m_pat) begin
                        if (m_cnt == 3) begin
                            m_state = 2; m_valid = 1;
                            m_code = lowest_zero(col_n) * 8 + m_row;
                        end else m_cnt++;
                    end else if (col_n != 8'hFF) begin
                        m_pat = col_n; m_cnt = 1;
                    end else begin
                        m_state = 0; m_row = (m_row + 1) % 8;
                    end
                end
                2: m_state = 3;
                default: if (scan_tick && col_n == 8'hFF) begin
                    m_state = 0; m_row = (m_row + 1) % 8;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            check(row_n == ~(8'h01 << m_row), "R3 row_n", int'(row_n), int'(~(8'h01 << m_row) & 8'hFF));
            check($countones(~row_n) == 1, "R2 one row low", $countones(~row_n), 1);
            check(key_valid == m_valid, "R8 key_valid", int'(key_valid), int'(m_valid));
            check(int'(key_code) == m_code, "R10 key_code", int'(key_code), m_code);
            if (key_valid) reports.push_back(int'(key_code));
        end
    end

    initial begin
        forever begin
            @(negedge clk); scan_tick = 1'b1;
            @(negedge clk); scan_tick = 1'b0;
            @(negedge clk);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic wait_row(input int r);
        while (row_n != ~(8'h01 << r)) @(negedge clk);
    endtask

    initial begin
        int exp_codes[$];
        exp_codes = '{29, 23, 0, 63, 10};
        repeat (3) @(negedge clk);
        // R1: reset values
        check(row_n == 8'hFE, "R1 row_n", int'(row_n), 254);
        check(key_valid == 1'b0, "R1 key_valid", int'(key_valid), 0);
        check(key_code == 6'd0, "R1 key_code", int'(key_code), 0);
        rst_n = 1'b1;
        compare_on = 1;
        // R3: free rotation past the wrap
        repeat (60) @(negedge clk);
        // R7: key at row 5, column 3 held long (R9 single report)
        pressed[5*8+3] = 1'b1;
        repeat (120) @(negedge clk);
        check(reports.size() == 1, "R9 one report while held", reports.size(), 1);
        pressed = '0;
        repeat (60) @(negedge clk);
        // R6: two keys on row 7, columns 6 and 2
        pressed[7*8+6] = 1'b1; pressed[7*8+2] = 1'b1;
        repeat (120) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);
        // R7: corner codes 0 and 63
        pressed[0] = 1'b1;
        repeat (120) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);
        pressed[63] = 1'b1;
        repeat (120) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);
        // R5: bounce, released after two samples
        pressed[4*8+6] = 1'b1;
        wait_row(4);
        repeat (6) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);
        check(reports.size() == 4, "R5 bounce not reported", reports.size(), 4);
        // R5: pattern change mid-confirm on row 2
        pressed[2*8+4] = 1'b1;
        wait_row(2);
        repeat (6) @(negedge clk);
        pressed = '0; pressed[2*8+1] = 1'b1;
        repeat (120) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);
        check(reports.size() == exp_codes.size(), "R5 report count", reports.size(), exp_codes.size());
        for (int i = 0; i < exp_codes.size(); i++) begin
            int got;
            got = (i < reports.size()) ? reports[i] : -1;
            check(got == exp_codes[i], "R7 reported code", got, exp_codes[i]);
        end
        finish_run();
    end
endmodule